// File: doc/BRIEF.md
# Frame Error Report Capture and Serial Readout

This block is the reporting back end of a frame checker that runs without pause. Each time the checker finishes a frame, a search stage hands over its result: a 16-bit signature plus the error kind and the error location. The block holds this result in a message register. It then copies the register into a holding (update) stage. A serial shift stage reads the holding stage out one bit at a time, so readout can go on while checking continues.

The block also drives an error flag. The flag is held low for a fixed minimum number of check ticks after every frame start. It rises only when the floor has elapsed and fresh error data has reached the holding stage, whichever of the two happens later. A check tick is one clock out of every 2^DIV_LOG2 clocks. The next frame start drops the flag and restarts the floor. A clean frame, meaning one with an all-zero signature, never raises the flag and never disturbs a report that is already stored.

Top module: `fault_log_readout`

## Requirements
- R1: After reset, crc_error and rd_data are 0, and a readout returns an all-zero 46-bit word.
- R2: The reported word is 46 bits, as follows.
  - The error kind sits in bits [1:0].
  - The bit location sits in [4:2].
  - The byte location sits in [15:5].
  - The frame address sits in [29:16].
  - The signature sits in [45:30].
- R3: Kind codes are 00 none, 01 single bit, 10 two adjacent bits and 11 multiple or scattered bits. When the kind is neither 01 nor 10, the frame, byte and bit location fields are stored as zero.
- R4: A result with an all-zero signature leaves the message register unchanged and does not raise crc_error.
- R5: The holding stage takes the message register contents on the clock edge after the result is captured. A load requested on the following edge returns the new word.
- R6: If a load is requested on the edge where the holding stage would be written, the load returns the previous contents. The write is then deferred by one edge, so the holding stage is never written while it is being sampled.
- R7: After a frame start, crc_error stays low until MIN_LOW (32) check ticks have elapsed.
- R8: crc_error rises one edge after the later of two events: the floor completing, or fresh data reaching the holding stage. With the defaults and a result on the first edge after the start, it is high after the 65th edge and low after the 64th. A result on the 70th edge gives a rise after the 72nd edge.
- R9: A frame start forces crc_error low on the next edge. It stays low through a whole frame that reports no error.
- R10: A second error result within a frame overwrites the first, and readout returns only the second.
- R11: The shift stage behaves as follows.
  - With rd_en high and rd_shift low, it loads.
  - With both high, it shifts toward bit 0, and rd_data presents bit 0, so the least significant bit comes out first.
  - Zeros fill in from the top.
  - With rd_en low, it holds regardless of rd_shift.
- R12: A check tick occurs once every 2^DIV_LOG2 clocks (2 by default), counted from the frame start, so the default floor spans 64 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe: a new frame signature calculation begins |
| res_valid | input | 1 | Strobe: search result fields are valid |
| res_syndrome | input | 16 | Frame signature; zero means clean |
| res_frame | input | 14 | Frame address of the error |
| res_byte | input | 11 | Byte location within the frame |
| res_bit | input | 3 | Bit location within the byte |
| res_kind | input | 2 | Error kind code |
| rd_shift | input | 1 | 1 selects shift, 0 selects load |
| rd_en | input | 1 | Enable for load or shift of the readout stage |
| crc_error | output | 1 | Error flag with minimum-low timing |
| rd_data | output | 1 | Serial readout, bit 0 of the shift stage |

## Verification
The bench samples the flag one edge before and one edge at its expected rise, for both an early result and a late result. A floor that is too short, or that ignores the holding-stage update, would show the flag one edge early. A load placed exactly on the holding-stage write edge must return the old word, so a design that writes and samples together returns the new word. A zero-signature result following a stored report must leave that report intact and the flag low; a design that captures clean results would read back a different word. Multi-error kinds must read back with zeroed locations, and a double result must read back only its second word. A stalled shift must keep its bit, and zeros must appear after all 46 bits have been shifted out.

// File: rtl/fault_log_pkg.sv
package fault_log_pkg;
    localparam int SYN_W = 16;
    localparam int FRM_W = 14;
    localparam int BYT_W = 11;
    localparam int BIT_W = 3;
    localparam int TYP_W = 2;
    localparam int MSG_W = SYN_W + FRM_W + BYT_W + BIT_W + TYP_W;

    typedef enum logic [TYP_W-1:0] {
        EK_NONE   = 2'b00,
        EK_SINGLE = 2'b01,
        EK_DOUBLE = 2'b10,
        EK_MULTI  = 2'b11
    } err_kind_e;

    // First member lands in the most significant bits.
    typedef struct packed {
        logic [SYN_W-1:0] syn;
        logic [FRM_W-1:0] frame;
        logic [BYT_W-1:0] byte_loc;
        logic [BIT_W-1:0] bit_loc;
        err_kind_e        kind;
    } err_msg_t;
endpackage

// File: rtl/fl_tick_gen.sv
module fl_tick_gen #(
    parameter int DIV_LOG2 = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    typedef struct packed {
        logic [DIV_LOG2-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) st_d.cnt = '0;
        else         st_d.cnt = st_q.cnt + DIV_LOG2'(1);
    end

    assign tick = &st_q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fl_flag_seq.sv
module fl_flag_seq #(
    parameter int MIN_LOW = 32,
    localparam int FLW = $clog2(MIN_LOW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           tick,
    input  logic           fresh_set,
    output logic           flag,
    output logic [FLW-1:0] floor_cnt
);
    typedef struct packed {
        logic [FLW-1:0] floor;
        logic           fresh;
        logic           flag;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic     floor_done;

    assign floor_done = (st_q.floor == FLW'(MIN_LOW));

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = '0;
        end else begin
            if (tick && !floor_done) st_d.floor = st_q.floor + FLW'(1);
            if (fresh_set)           st_d.fresh = 1'b1;
            if (st_q.fresh && floor_done) st_d.flag = 1'b1;
        end
    end

    assign flag      = st_q.flag;
    assign floor_cnt = st_q.floor;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fl_msg_chain.sv
module fl_msg_chain
    import fault_log_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     res_valid,
    input  err_msg_t res_msg,
    input  logic     load_req,
    input  logic     shift_req,
    output logic     sdo,
    output logic     upd_wr,
    output err_msg_t emr_q,
    output err_msg_t upd_q
);
    typedef struct packed {
        err_msg_t         emr;
        logic             pend;
        err_msg_t         upd;
        logic [MSG_W-1:0] shr;
    } chain_st_t;

    chain_st_t st_d, st_q;
    err_msg_t  clean;
    logic      has_loc;

    assign has_loc = (res_msg.kind == EK_SINGLE) || (res_msg.kind == EK_DOUBLE);

    always_comb begin
        clean = res_msg;
        if (!has_loc) begin
            clean.frame    = '0;
            clean.byte_loc = '0;
            clean.bit_loc  = '0;
        end
    end

    // Holding stage write waits while the shift stage samples it.
    assign upd_wr = st_q.pend && !load_req;

    always_comb begin
        st_d = st_q;
        if (res_valid && (res_msg.syn != '0)) begin
            st_d.emr  = clean;
            st_d.pend = 1'b1;
        end else if (upd_wr) begin
            st_d.pend = 1'b0;
        end
        if (upd_wr) st_d.upd = st_q.emr;
        if (load_req)       st_d.shr = st_q.upd;
        else if (shift_req) st_d.shr = st_q.shr >> 1;
    end

    assign sdo   = st_q.shr[0];
    assign emr_q = st_q.emr;
    assign upd_q = st_q.upd;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fault_log_readout.sv
module fault_log_readout
    import fault_log_pkg::*;
#(
    parameter int MIN_LOW  = 32,
    parameter int DIV_LOG2 = 1,
    localparam int FLW = $clog2(MIN_LOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             res_valid,
    input  logic [SYN_W-1:0] res_syndrome,
    input  logic [FRM_W-1:0] res_frame,
    input  logic [BYT_W-1:0] res_byte,
    input  logic [BIT_W-1:0] res_bit,
    input  logic [TYP_W-1:0] res_kind,
    input  logic             rd_shift,
    input  logic             rd_en,
    output logic             crc_error,
    output logic             rd_data
);
    err_msg_t       res_msg;
    err_msg_t       emr_q;
    err_msg_t       upd_q;
    logic           tick;
    logic           upd_wr;
    logic           load_req;
    logic           shift_req;
    logic [FLW-1:0] floor_cnt;

    always_comb begin
        res_msg.syn      = res_syndrome;
        res_msg.frame    = res_frame;
        res_msg.byte_loc = res_byte;
        res_msg.bit_loc  = res_bit;
        res_msg.kind     = err_kind_e'(res_kind);
    end

    assign load_req  = rd_en && !rd_shift;
    assign shift_req = rd_en && rd_shift;

    fl_tick_gen #(.DIV_LOG2(DIV_LOG2)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_start),
        .tick    (tick)
    );

    fl_flag_seq #(.MIN_LOW(MIN_LOW)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (frame_start),
        .tick      (tick),
        .fresh_set (upd_wr),
        .flag      (crc_error),
        .floor_cnt (floor_cnt)
    );

    fl_msg_chain u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_msg   (res_msg),
        .load_req  (load_req),
        .shift_req (shift_req),
        .sdo       (rd_data),
        .upd_wr    (upd_wr),
        .emr_q     (emr_q),
        .upd_q     (upd_q)
    );
endmodule

// File: rtl/fl_checker.sv
module fl_checker
    import fault_log_pkg::*;
#(
    parameter int MIN_LOW = 32,
    parameter int FLW     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             res_valid,
    input logic [SYN_W-1:0] res_syndrome,
    input logic             rd_en,
    input logic             rd_shift,
    input logic             crc_error,
    input logic             rd_data,
    input logic [FLW-1:0]   floor_cnt,
    input err_msg_t         emr_q,
    input err_msg_t         upd_q
);
    AST_RISE_AFTER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_error) |-> ($past(floor_cnt) == FLW'(MIN_LOW))); // R7

    AST_START_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !crc_error); // R9

    AST_NO_WRITE_DURING_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_shift) |=> $stable(upd_q)); // R6

    AST_CLEAN_KEEPS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_syndrome == '0)) |=> $stable(emr_q)); // R4

    AST_IDLE_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R11

    AST_NOLOC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(emr_q.kind == EK_SINGLE || emr_q.kind == EK_DOUBLE)
        |-> (emr_q.frame == '0 && emr_q.byte_loc == '0 && emr_q.bit_loc == '0)); // R3
endmodule

bind fault_log_readout fl_checker #(.MIN_LOW(MIN_LOW), .FLW(FLW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .res_valid    (res_valid),
    .res_syndrome (res_syndrome),
    .rd_en        (rd_en),
    .rd_shift     (rd_shift),
    .crc_error    (crc_error),
    .rd_data      (rd_data),
    .floor_cnt    (floor_cnt),
    .emr_q        (emr_q),
    .upd_q        (upd_q)
);

// File: tb/sim_fault_log_readout.sv
module sim_fault_log_readout;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_syndrome = '0;
    logic [13:0] res_frame = '0;
    logic [10:0] res_byte = '0;
    logic [2:0]  res_bit = '0;
    logic [1:0]  res_kind = '0;
    logic        rd_shift = 1'b0;
    logic        rd_en = 1'b0;
    logic        crc_error;
    logic        rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [45:0] rd_word;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fault_log_readout u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .res_valid(res_valid),
        .res_syndrome(res_syndrome), .res_frame(res_frame), .res_byte(res_byte),
        .res_bit(res_bit), .res_kind(res_kind), .rd_shift(rd_shift), .rd_en(rd_en),
        .crc_error(crc_error), .rd_data(rd_data)
    );

    // Inputs and expected readouts: {syn, frame, byte, bit, kind}
    localparam logic [45:0] VIN [4] = '{
        {16'hA5C3, 14'h1234, 11'h155, 3'd6, 2'b01},
        {16'h0001, 14'h3FFF, 11'h7FF, 3'd7, 2'b10},
        {16'hFFFF, 14'h0ABC, 11'h2AA, 3'd5, 2'b11},
        {16'h8000, 14'h0001, 11'h002, 3'd3, 2'b00}
    };
    localparam logic [45:0] VEXP [4] = '{
        {16'hA5C3, 14'h1234, 11'h155, 3'd6, 2'b01},
        {16'h0001, 14'h3FFF, 11'h7FF, 3'd7, 2'b10},
        {16'hFFFF, 14'h0000, 11'h000, 3'd0, 2'b11},
        {16'h8000, 14'h0000, 11'h000, 3'd0, 2'b00}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_frame();
        frame_start = 1'b1;
        cyc(1);
        frame_start = 1'b0;
    endtask

    task automatic post(input logic [45:0] w);
        res_valid = 1'b1;
        {res_syndrome, res_frame, res_byte, res_bit, res_kind} = w;
        cyc(1);
        res_valid = 1'b0;
    endtask

    task automatic readout();
        rd_en = 1'b1;
        rd_shift = 1'b0;
        cyc(1);
        rd_shift = 1'b1;
        for (int i = 0; i < 46; i++) begin
            rd_word[i] = rd_data;
            cyc(1);
        end
        rd_en = 1'b0;
        rd_shift = 1'b0;
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        // R1: reset state
        cyc(3);
        chk("R1 crc_error in reset", 64'(crc_error), 64'd0);
        chk("R1 rd_data in reset", 64'(rd_data), 64'd0);
        rst_n = 1'b1;
        cyc(2);
        readout();
        chk("R1 readout after reset", 64'(rd_word), 64'd0);

        // Table walk: early result, floor timing, readout contents
        for (int v = 0; v < 4; v++) begin
            start_frame();
            chk("R9 flag low after start", 64'(crc_error), 64'd0);
            post(VIN[v]);
            cyc(63);
            chk("R7/R12 flag low at floor edge 64", 64'(crc_error), 64'd0);
            cyc(1);
            chk("R8/R12 flag high after edge 65", 64'(crc_error), 64'd1);
            readout();
            chk("R2/R3 readout word", 64'(rd_word), 64'(VEXP[v]));
            chk("R8 flag held during readout", 64'(crc_error), 64'd1);
        end

        // R9: start drops flag; frame without result stays low
        start_frame();
        chk("R9 start drops flag", 64'(crc_error), 64'd0);
        cyc(80);
        chk("R9 no result keeps flag low", 64'(crc_error), 64'd0);

        // R4: clean result ignored
        post({16'h0000, 14'h0155, 11'h0AA, 3'd1, 2'b01});
        cyc(5);
        chk("R4 clean result no flag", 64'(crc_error), 64'd0);
        readout();
        chk("R4 report preserved", 64'(rd_word), 64'(VEXP[3]));

        // R8: late result
        start_frame();
        cyc(69);
        post(VIN[0]);
        chk("R8 late low edge 70", 64'(crc_error), 64'd0);
        cyc(1);
        chk("R8 late low edge 71", 64'(crc_error), 64'd0);
        cyc(1);
        chk("R8 late high edge 72", 64'(crc_error), 64'd1);

        // R6: load on the holding-stage write edge returns old word
        post(VIN[1]);
        readout();
        chk("R6 collision returns old", 64'(rd_word), 64'(VEXP[0]));
        readout();
        chk("R6 deferred write lands", 64'(rd_word), 64'(VEXP[1]));

        // R5: load two edges after capture returns new word
        post(VIN[2]);
        cyc(1);
        readout();
        chk("R5 update one edge after capture", 64'(rd_word), 64'(VEXP[2]));

        // R10: overwrite within a frame
        start_frame();
        post(VIN[0]);
        post(VIN[3]);
        cyc(70);
        chk("R10 flag set", 64'(crc_error), 64'd1);
        readout();
        chk("R10 second result wins", 64'(rd_word), 64'(VEXP[3]));

        // R11: hold, LSB first, zero fill
        post(VIN[0]);
        cyc(2);
        rd_en = 1'b1;
        rd_shift = 1'b0;
        cyc(1);
        rd_en = 1'b0;
        rd_shift = 1'b1;
        chk("R11 bit0 after load", 64'(rd_data), 64'(VEXP[0][0]));
        cyc(5);
        chk("R11 hold with enable low", 64'(rd_data), 64'(VEXP[0][0]));
        rd_en = 1'b1;
        cyc(1);
        chk("R11 bit1 after one shift", 64'(rd_data), 64'(VEXP[0][1]));
        cyc(44);
        chk("R11 bit45 after 45 shifts", 64'(rd_data), 64'(VEXP[0][45]));
        cyc(1);
        chk("R11 zero fill after 46 shifts", 64'(rd_data), 64'd0);
        rd_en = 1'b0;
        rd_shift = 1'b0;

        done = 1'b1;
        report();
    end
endmodule